// File: doc/BRIEF.md
# Bus Controller Status Flag Register

This block keeps three sticky status flags for a two-wire serial bus controller and presents them, together with five status bits that other logic produces, as one 8-bit status byte. The bus engine sends it single-cycle event pulses: a start seen on the bus, a stop seen on the bus, a start issued by this node, and a lost arbitration. It also sends the upper nibble of each received address byte with a strobe that fires on the rising edge of the eighth bus clock. The CPU side supplies a release command, a one-bit-write strobe, a read strobe and the interface enable.

The master flag is held by a two-state role machine. Its states are `ROLE_IDLE` (the node is a slave or on standby) and `ROLE_MASTER` (the node owns the bus). The transition **claim** goes from `ROLE_IDLE` to `ROLE_MASTER` when this node issues a start. The transition **drop** goes from `ROLE_MASTER` to `ROLE_IDLE` on any master clear condition. The extension-code flag and the arbitration-loss flag are instances of one generic sticky flag cell. The flag values are registered, so during the read cycle the status byte shows the values from before the clear-on-read that the read triggers.

Top module: `busctl_status_reg`

## Requirements
- R1: After reset the status byte `stat_o` is 0x00.
- R2: `stat_o[7]` is the master flag, `stat_o[6]` is the arbitration-loss flag, `stat_o[5]` is the extension-code flag, and `stat_o[4:0]` equals `aux_bits_i` in the same cycle.
- R3: In the cycle after `addr8_stb_i` is high with `addr_hi_i` equal to 4'b0000 or 4'b1111, the extension-code flag is 1, unless a clear condition of R4 occurs in the same cycle. Any other nibble leaves the flag unchanged.
- R4: The extension-code flag goes to 0 in the cycle after `start_det_i`, `stop_det_i`, `release_i`, `bitwr_i` or an enable fall. The clear wins over a set in the same cycle.
- R5: The master flag goes to 1 in the cycle after `start_gen_i` (claim), unless a clear condition of R6 occurs in the same cycle.
- R6: The master flag goes to 0 in the cycle after `stop_det_i`, `arb_lost_i`, `release_i`, `bitwr_i` or an enable fall (drop). The clear wins over `start_gen_i`.
- R7: The arbitration-loss flag goes to 1 in the cycle after `arb_lost_i` and holds until it is cleared.
- R8: The arbitration-loss flag goes to 0 in the cycle after a `rd_stb_i` pulse. If `arb_lost_i` is high in the same cycle, the flag is 1 instead.
- R9: An enable fall or `bitwr_i` clears the arbitration-loss flag, and this clear wins over `arb_lost_i` in the same cycle.
- R10: In a cycle where `rd_stb_i` is high, `stat_o` shows the flag values from before that read.
- R11: An enable fall is a cycle where `enable_i` is 0 and was 1 in the previous cycle. When `enable_i` stays at 0, or rises, nothing is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Interface enable |
| release_i | input | 1 | Release-communication command pulse |
| bitwr_i | input | 1 | One-bit write to another status bit; clears all flags |
| rd_stb_i | input | 1 | Status read strobe, one cycle |
| start_det_i | input | 1 | Start condition seen on the bus |
| stop_det_i | input | 1 | Stop condition seen on the bus |
| start_gen_i | input | 1 | Start condition issued by this node |
| arb_lost_i | input | 1 | Arbitration lost |
| addr8_stb_i | input | 1 | Eighth-clock rising-edge strobe of the address byte |
| addr_hi_i | input | 4 | Upper nibble of the received address byte |
| aux_bits_i | input | 5 | External status bits placed in bits 4..0 |
| stat_o | output | 8 | Packed status byte |

## Verification
Directed patterns come first. They pair each set event with each of its clear events in the same cycle, which shows whether clear-over-set priority is kept per flag and whether the read-versus-loss exception is present. Nibbles 0000, 1111, 1000 and 0111 show whether the extension decode matches the exact nibbles or only one bit. A held-low enable and a rising enable are compared with a falling enable, which shows whether the edge detector reacts only to a fall. A long random run with sparse events is then compared every cycle against a behavioural model. This catches priority mix-ups that only appear when several events arrive together.

// File: rtl/busctl_status_pkg.sv
package busctl_status_pkg;
    typedef enum logic {
        ROLE_IDLE   = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    localparam int unsigned STAT_W = 8;
    localparam int unsigned AUX_W  = 5;
    localparam int unsigned NIB_W  = 4;
endpackage

// File: rtl/busctl_en_edge.sv
module busctl_en_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic fall_o
);
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    assign fall_o = en_q & ~en_i;
endmodule

// File: rtl/busctl_sticky_flag.sv
module busctl_sticky_flag #(
    parameter bit SET_OVER_SOFT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_hard_i,
    input  logic clr_soft_i,
    output logic flag_o
);
    logic flag_d;

    generate
        if (SET_OVER_SOFT) begin : g_set_wins
            always_comb begin
                if (clr_hard_i)      flag_d = 1'b0;
                else if (set_i)      flag_d = 1'b1;
                else if (clr_soft_i) flag_d = 1'b0;
                else                 flag_d = flag_o;
            end
        end else begin : g_clr_wins
            always_comb begin
                if (clr_hard_i || clr_soft_i) flag_d = 1'b0;
                else if (set_i)               flag_d = 1'b1;
                else                          flag_d = flag_o;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= flag_d;
    end

    assert_hard_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hard_i |=> !flag_o);
endmodule

// File: rtl/busctl_role_fsm.sv
module busctl_role_fsm
    import busctl_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic claim_i,
    input  logic drop_i,
    output logic master_o
);
    role_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ROLE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROLE_IDLE:   if (claim_i && !drop_i) state_d = ROLE_MASTER;
            ROLE_MASTER: if (drop_i)             state_d = ROLE_IDLE;
            default:     state_d = ROLE_IDLE;
        endcase
    end

    always_comb begin
        master_o = (state_q == ROLE_MASTER);
    end

    assert_drop_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop_i |=> !master_o);
    assert_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_i && !drop_i) |=> master_o);
endmodule

// File: rtl/busctl_status_reg.sv
module busctl_status_reg
    import busctl_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             release_i,
    input  logic             bitwr_i,
    input  logic             rd_stb_i,
    input  logic             start_det_i,
    input  logic             stop_det_i,
    input  logic             start_gen_i,
    input  logic             arb_lost_i,
    input  logic             addr8_stb_i,
    input  logic [NIB_W-1:0] addr_hi_i,
    input  logic [AUX_W-1:0] aux_bits_i,
    output logic [STAT_W-1:0] stat_o
);
    localparam logic [NIB_W-1:0] NIB_LO = '0;
    localparam logic [NIB_W-1:0] NIB_HI = '1;

    logic en_fall;
    logic clr_all;
    logic ext_hit;
    logic ext_clr;
    logic mst_drop;
    logic f_master, f_arb, f_ext;

    busctl_en_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable_i),
        .fall_o (en_fall)
    );

    // R11: only a 1->0 enable transition clears; bit write acts the same (R4, R6, R9)
    assign clr_all  = en_fall | bitwr_i;
    assign ext_hit  = addr8_stb_i & ((addr_hi_i == NIB_LO) | (addr_hi_i == NIB_HI));
    assign ext_clr  = clr_all | start_det_i | stop_det_i | release_i;
    assign mst_drop = clr_all | stop_det_i | arb_lost_i | release_i;

    busctl_sticky_flag #(.SET_OVER_SOFT(1'b0)) u_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (ext_hit),
        .clr_hard_i (ext_clr),
        .clr_soft_i (1'b0),
        .flag_o     (f_ext)
    );

    busctl_sticky_flag #(.SET_OVER_SOFT(1'b1)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (arb_lost_i),
        .clr_hard_i (clr_all),
        .clr_soft_i (rd_stb_i),
        .flag_o     (f_arb)
    );

    busctl_role_fsm u_role (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim_i  (start_gen_i),
        .drop_i   (mst_drop),
        .master_o (f_master)
    );

    assign stat_o = {f_master, f_arb, f_ext, aux_bits_i};

    assert_ext_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr8_stb_i && (addr_hi_i == NIB_HI) && !ext_clr) |=> stat_o[5]);
    assert_ext_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det_i || stop_det_i || release_i) |=> !stat_o[5]);
    assert_arb_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost_i && !en_fall && !bitwr_i) |=> (stat_o[6] && !stat_o[7]));
    assert_fall_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> (stat_o[7:5] == 3'b000));
endmodule

// File: tb/busctl_status_reg_tb_top.sv
`timescale 1ns/1ps
module busctl_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, release_i = 1'b0, bitwr_i = 1'b0, rd_stb_i = 1'b0;
    logic       start_det_i = 1'b0, stop_det_i = 1'b0, start_gen_i = 1'b0, arb_lost_i = 1'b0;
    logic       addr8_stb_i = 1'b0;
    logic [3:0] addr_hi_i = 4'h0;
    logic [4:0] aux_bits_i = 5'h0;
    logic [7:0] stat_o;

    int total = 0;
    int bad = 0;
    int m_mst = 0, m_arb = 0, m_ext = 0, m_en_prev = 0;

    always #2 clk = ~clk;

    busctl_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .release_i(release_i),
        .bitwr_i(bitwr_i), .rd_stb_i(rd_stb_i), .start_det_i(start_det_i),
        .stop_det_i(stop_det_i), .start_gen_i(start_gen_i), .arb_lost_i(arb_lost_i),
        .addr8_stb_i(addr8_stb_i), .addr_hi_i(addr_hi_i), .aux_bits_i(aux_bits_i),
        .stat_o(stat_o)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_byte();
        return {m_mst[0], m_arb[0], m_ext[0], aux_bits_i};
    endfunction

    // behavioural reference: advance by one clock using current inputs
    task automatic model_step();
        int fall = (m_en_prev == 1 && enable_i == 1'b0) ? 1 : 0;
        int wipe = fall | int'(bitwr_i);
        if (wipe || start_det_i || stop_det_i || release_i) m_ext = 0;
        else if (addr8_stb_i && (addr_hi_i == 4'h0 || addr_hi_i == 4'hF)) m_ext = 1;
        if (wipe) m_arb = 0;
        else if (arb_lost_i) m_arb = 1;
        else if (rd_stb_i) m_arb = 0;
        if (wipe || stop_det_i || arb_lost_i || release_i) m_mst = 0;
        else if (start_gen_i) m_mst = 1;
        m_en_prev = int'(enable_i);
    endtask

    task automatic idle_inputs();
        release_i = 0; bitwr_i = 0; rd_stb_i = 0; start_det_i = 0; stop_det_i = 0;
        start_gen_i = 0; arb_lost_i = 0; addr8_stb_i = 0;
    endtask

    // inputs already set (at a negedge); R10 check on reads, then clock and compare
    task automatic cyc(string req);
        #0.5;
        if (rd_stb_i) chk("R10", stat_o, model_byte());
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle_inputs();
        #0.5;
        chk(req, stat_o, model_byte());
    endtask

    initial begin : watchdog
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #10;
        @(negedge clk);
        chk("R1", stat_o, 8'h00);
        rst_n = 1;
        enable_i = 1;
        cyc("R1");
        aux_bits_i = 5'h15; #0.5; chk("R2", stat_o, model_byte());
        // R3 nibble patterns
        addr8_stb_i = 1; addr_hi_i = 4'h8; cyc("R3");
        addr8_stb_i = 1; addr_hi_i = 4'h7; cyc("R3");
        addr8_stb_i = 1; addr_hi_i = 4'hF; cyc("R3");
        start_det_i = 1; cyc("R4");
        addr8_stb_i = 1; addr_hi_i = 4'h0; cyc("R3");
        addr8_stb_i = 1; addr_hi_i = 4'h0; stop_det_i = 1; cyc("R4");
        addr8_stb_i = 1; addr_hi_i = 4'h0; cyc("R3");
        release_i = 1; cyc("R4");
        // R5 / R6 master
        start_gen_i = 1; cyc("R5");
        start_gen_i = 1; stop_det_i = 1; cyc("R6");
        start_gen_i = 1; cyc("R5");
        bitwr_i = 1; cyc("R6");
        start_gen_i = 1; cyc("R5");
        // R7 loss, drops master
        arb_lost_i = 1; cyc("R7");
        cyc("R7");
        rd_stb_i = 1; cyc("R8");
        arb_lost_i = 1; cyc("R7");
        rd_stb_i = 1; arb_lost_i = 1; cyc("R8");
        arb_lost_i = 1; bitwr_i = 1; cyc("R9");
        // R11 enable edges
        arb_lost_i = 1; start_gen_i = 1; cyc("R7");
        enable_i = 0; arb_lost_i = 1; cyc("R9");
        arb_lost_i = 1; cyc("R11");
        cyc("R11");
        enable_i = 1; cyc("R11");
        addr8_stb_i = 1; addr_hi_i = 4'hF; cyc("R3");
        enable_i = 0; cyc("R11");
        // random phase compared every cycle
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 40) == 0) enable_i = ~enable_i;
            release_i   = ($urandom_range(0, 15) == 0);
            bitwr_i     = ($urandom_range(0, 25) == 0);
            rd_stb_i    = ($urandom_range(0, 6) == 0);
            start_det_i = ($urandom_range(0, 9) == 0);
            stop_det_i  = ($urandom_range(0, 9) == 0);
            start_gen_i = ($urandom_range(0, 4) == 0);
            arb_lost_i  = ($urandom_range(0, 8) == 0);
            addr8_stb_i = ($urandom_range(0, 3) == 0);
            case ($urandom_range(0, 2))
                0: addr_hi_i = 4'h0;
                1: addr_hi_i = 4'hF;
                default: addr_hi_i = 4'($urandom_range(0, 15));
            endcase
            aux_bits_i = 5'($urandom_range(0, 31));
            cyc("R2");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule